// File: doc/BRIEF.md
# Reference Input Validity Qualifier

This block decides, on every clock, which of six reference clock inputs may take part in automatic reference selection. For each input it takes four monitor results: a no-activity alarm, a frequency hard alarm, a phase-lock alarm and a loss-of-signal disqualify bit. It combines them under one of two rule sets. The primary-loop rule set honours the phase-lock alarm. The secondary-loop rule set disregards that alarm.

Under the primary-loop rules, an optional fast-switch criterion can also disqualify the input that is currently selected. A small counter is cleared by every detected edge of the selected clock and advances on each expected-period tick of a timebase. Once the counter reaches two missed periods, the selected input is declared invalid. The registered valid vector is compared with its previous value. Any change, in either direction, sets a sticky per-input change flag. Software clears the flags with a write-one-to-clear strobe, and an interrupt is raised while any flag is set.

Top module: `refclk_validity_qual`

## Requirements
- R1: An input whose no-activity alarm or frequency hard alarm is set is reported invalid.
- R2: An input whose loss-of-signal disqualify bit is set is reported invalid.
- R3: With `rule_secondary` = 0 (primary rules), a set phase-lock alarm makes its input invalid. With `rule_secondary` = 1, the phase-lock alarm has no effect on validity.
- R4: With primary rules and `fast_sw_en` = 1, the input indexed by `sel_idx` is invalid while the missed-period count is 2 or more. The other inputs are not affected. With `fast_sw_en` = 0 or secondary rules, the count has no effect.
- R5: The missed-period count goes to 0 on any cycle with `sel_edge` = 1, even if `period_tick` is also 1. Otherwise it advances by one on each `period_tick` and saturates at 2.
- R6: `valid_o` is registered. Bit i reflects the input conditions and the missed-period count present in the cycle before the clock edge that updates it.
- R7: Whenever bit i of `valid_o` changes value (0 to 1 or 1 to 0), `chg_flag_o[i]` becomes 1 at the same edge. It then stays 1 until it is cleared.
- R8: A 1 on `chg_clr[i]` clears `chg_flag_o[i]` at the next edge. If bit i changes in that same cycle, the flag stays 1.
- R9: `irq_o` is 1 exactly when at least one bit of `chg_flag_o` is 1.
- R10: During reset, `valid_o`, `chg_flag_o` and `irq_o` are all 0, and the missed-period count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alm_noact | input | 6 | Per-input no-activity alarm |
| alm_freq | input | 6 | Per-input frequency hard alarm |
| alm_phase | input | 6 | Per-input phase-lock alarm |
| los_disq | input | 6 | Per-input loss-of-signal disqualify |
| sel_idx | input | 3 | Index of the currently selected input (0..5) |
| sel_edge | input | 1 | An edge of the selected clock was detected this cycle |
| period_tick | input | 1 | One expected period of the selected clock has elapsed |
| rule_secondary | input | 1 | 0: primary-loop rules, 1: secondary-loop rules |
| fast_sw_en | input | 1 | Enables the missed-period criterion |
| chg_clr | input | 6 | Write-one-to-clear strobe for the change flags |
| valid_o | output | 6 | Registered per-input valid status |
| chg_flag_o | output | 6 | Sticky per-input change flags |
| irq_o | output | 1 | Interrupt, set while any change flag is set |

## Verification
The bench targets the missed-period criterion at its threshold. It also checks a same-cycle edge and tick, and moves the selected index so that only that input is affected. A design with an off-by-one threshold, or one that lets a tick win over an edge, would drop or keep the selected input one period early or late. The bench also sets a change and a clear on the same flag in the same cycle; a design with the wrong priority would lose the event and drop the interrupt. Finally it toggles the rule set while a phase-lock alarm is held. This exposes a design that applies the phase alarm under the secondary rules, or one that misses the invalid-to-valid change this produces.

// File: rtl/rvq_pkg.sv
package rvq_pkg;
  typedef enum logic {
    RULES_PRIMARY   = 1'b0,
    RULES_SECONDARY = 1'b1
  } rule_set_e;
endpackage

// File: rtl/rvq_miss_count.sv
// Missed-period counter for the selected reference clock.
module rvq_miss_count #(
  parameter int MISS_LIMIT = 2,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_edge,
  input  logic             period_tick,
  output logic [CNT_W-1:0] miss_cnt
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MISS_LIMIT);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = sel_edge | (period_tick & (miss_cnt < LIM));
    if (sel_edge) cnt_d = '0;
    else          cnt_d = miss_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      miss_cnt <= '0;
    else if (cnt_en) miss_cnt <= cnt_d;
  end
endmodule

// File: rtl/rvq_rule_eval.sv
// Per-input combinational qualification under the chosen rule set.
module rvq_rule_eval
  import rvq_pkg::*;
#(
  parameter int NUM_IN     = 6,
  parameter int MISS_LIMIT = 2,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic [NUM_IN-1:0] alm_noact,
  input  logic [NUM_IN-1:0] alm_freq,
  input  logic [NUM_IN-1:0] alm_phase,
  input  logic [NUM_IN-1:0] los_disq,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic [CNT_W-1:0]  miss_cnt,
  input  rule_set_e         rules,
  input  logic              fast_sw_en,
  output logic [NUM_IN-1:0] valid_d
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MISS_LIMIT);

  logic primary;
  logic miss_fail;

  always_comb begin
    primary   = (rules == RULES_PRIMARY);
    miss_fail = primary & fast_sw_en & (miss_cnt >= LIM);
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic monitor_ok;
    logic phase_ok;
    logic is_sel;
    always_comb begin
      monitor_ok = ~alm_noact[i] & ~alm_freq[i] & ~los_disq[i];
      phase_ok   = ~(primary & alm_phase[i]);
      is_sel     = (sel_idx == SEL_W'(i));
      valid_d[i] = monitor_ok & phase_ok & ~(is_sel & miss_fail);
    end
  end
endmodule

// File: rtl/rvq_change_track.sv
// Registers the valid vector and keeps sticky change flags.
module rvq_change_track #(
  parameter int NUM_IN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] valid_d,
  input  logic [NUM_IN-1:0] chg_clr,
  output logic [NUM_IN-1:0] valid_q,
  output logic [NUM_IN-1:0] flag_q
);
  logic [NUM_IN-1:0] toggled;
  logic [NUM_IN-1:0] flag_d;

  always_comb begin
    toggled = valid_d ^ valid_q;
    flag_d  = (flag_q & ~chg_clr) | toggled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      flag_q  <= '0;
    end else begin
      valid_q <= valid_d;
      flag_q  <= flag_d;
    end
  end
endmodule

// File: rtl/refclk_validity_qual.sv
module refclk_validity_qual
  import rvq_pkg::*;
#(
  parameter int NUM_IN     = 6,
  parameter int MISS_LIMIT = 2,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] alm_noact,
  input  logic [NUM_IN-1:0] alm_freq,
  input  logic [NUM_IN-1:0] alm_phase,
  input  logic [NUM_IN-1:0] los_disq,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic              sel_edge,
  input  logic              period_tick,
  input  logic              rule_secondary,
  input  logic              fast_sw_en,
  input  logic [NUM_IN-1:0] chg_clr,
  output logic [NUM_IN-1:0] valid_o,
  output logic [NUM_IN-1:0] chg_flag_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  miss_cnt;
  logic [NUM_IN-1:0] valid_d;
  rule_set_e         rules;

  always_comb rules = rule_secondary ? RULES_SECONDARY : RULES_PRIMARY;

  rvq_miss_count #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_edge    (sel_edge),
    .period_tick (period_tick),
    .miss_cnt    (miss_cnt)
  );

  rvq_rule_eval #(.NUM_IN(NUM_IN), .MISS_LIMIT(MISS_LIMIT)) u_eval (
    .alm_noact  (alm_noact),
    .alm_freq   (alm_freq),
    .alm_phase  (alm_phase),
    .los_disq   (los_disq),
    .sel_idx    (sel_idx),
    .miss_cnt   (miss_cnt),
    .rules      (rules),
    .fast_sw_en (fast_sw_en),
    .valid_d    (valid_d)
  );

  rvq_change_track #(.NUM_IN(NUM_IN)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_d (valid_d),
    .chg_clr (chg_clr),
    .valid_q (valid_o),
    .flag_q  (chg_flag_o)
  );

  always_comb irq_o = |chg_flag_o;
endmodule

// File: rtl/rvq_checker.sv
module rvq_checker #(
  parameter int NUM_IN     = 6,
  parameter int MISS_LIMIT = 2,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] alm_noact,
  input logic [NUM_IN-1:0] alm_freq,
  input logic [NUM_IN-1:0] alm_phase,
  input logic [NUM_IN-1:0] los_disq,
  input logic [SEL_W-1:0]  sel_idx,
  input logic              sel_edge,
  input logic              rule_secondary,
  input logic              fast_sw_en,
  input logic [NUM_IN-1:0] chg_clr,
  input logic [NUM_IN-1:0] valid_o,
  input logic [NUM_IN-1:0] chg_flag_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  miss_cnt
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MISS_LIMIT);

  p_alarm_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((valid_o & $past(alm_noact | alm_freq)) == '0));

  p_los_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((valid_o & $past(los_disq)) == '0));

  p_phase_primary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rule_secondary |=> ((valid_o & $past(alm_phase)) == '0));

  p_miss_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rule_secondary && fast_sw_en && miss_cnt >= LIM && sel_idx < SEL_W'(NUM_IN))
    |=> !valid_o[$past(sel_idx)]);

  p_edge_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_edge |=> (miss_cnt == '0));

  p_change_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_flag_o & (valid_o ^ $past(valid_o))) == (valid_o ^ $past(valid_o))));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_flag_o & $past(chg_flag_o & ~chg_clr)) == $past(chg_flag_o & ~chg_clr)));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (valid_o != $past(valid_o)));
endmodule

bind refclk_validity_qual rvq_checker #(.NUM_IN(NUM_IN), .MISS_LIMIT(MISS_LIMIT)) u_rvq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alm_noact      (alm_noact),
  .alm_freq       (alm_freq),
  .alm_phase      (alm_phase),
  .los_disq       (los_disq),
  .sel_idx        (sel_idx),
  .sel_edge       (sel_edge),
  .rule_secondary (rule_secondary),
  .fast_sw_en     (fast_sw_en),
  .chg_clr        (chg_clr),
  .valid_o        (valid_o),
  .chg_flag_o     (chg_flag_o),
  .irq_o          (irq_o),
  .miss_cnt       (miss_cnt)
);

// File: tb/test_refclk_validity_qual.sv
module test_refclk_validity_qual;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] alm_noact, alm_freq, alm_phase, los_disq, chg_clr;
  logic [2:0] sel_idx;
  logic       sel_edge, period_tick, rule_secondary, fast_sw_en;
  logic [5:0] valid_o, chg_flag_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  refclk_validity_qual i_refclk_validity_qual (
    .clk(clk), .rst_n(rst_n),
    .alm_noact(alm_noact), .alm_freq(alm_freq), .alm_phase(alm_phase),
    .los_disq(los_disq), .sel_idx(sel_idx), .sel_edge(sel_edge),
    .period_tick(period_tick), .rule_secondary(rule_secondary),
    .fast_sw_en(fast_sw_en), .chg_clr(chg_clr),
    .valid_o(valid_o), .chg_flag_o(chg_flag_o), .irq_o(irq_o)
  );

  // Behavioural reference model, advanced at every rising edge
  int        m_miss;
  bit [5:0]  m_valid, m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_miss = 0; m_valid = '0; m_flag = '0;
    end else begin
      bit [5:0] nv;
      for (int i = 0; i < 6; i++) begin
        bit ok;
        ok = !alm_noact[i] && !alm_freq[i] && !los_disq[i];
        if (!rule_secondary && alm_phase[i]) ok = 1'b0;
        if (!rule_secondary && fast_sw_en && i == int'(sel_idx) && m_miss >= 2) ok = 1'b0;
        nv[i] = ok;
      end
      m_flag  = (m_flag & ~chg_clr) | (nv ^ m_valid);
      m_valid = nv;
      if (sel_edge) m_miss = 0;
      else if (period_tick && m_miss < 2) m_miss = m_miss + 1;
    end
  end

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 model valid_o", valid_o, m_valid);
      chk("R7 model chg_flag_o", chg_flag_o, m_flag);
      chk("R9 model irq_o", {5'b0, irq_o}, {5'b0, m_flag != 0});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    alm_noact = '0; alm_freq = '0; alm_phase = '0; los_disq = '0;
    chg_clr = '0; sel_idx = 3'd0; sel_edge = 1'b0; period_tick = 1'b0;
    rule_secondary = 1'b0; fast_sw_en = 1'b0;
  endtask

  initial begin
    fork
      begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    idle_inputs();
    rst_n = 1'b0;
    step(3);
    chk("R10 reset valid_o", valid_o, 6'h00);
    chk("R10 reset chg_flag_o", chg_flag_o, 6'h00);
    chk("R10 reset irq_o", {5'b0, irq_o}, 6'h00);

    rst_n = 1'b1;
    step(1);
    chk("R6 all valid after release", valid_o, 6'h3f);
    chk("R7 invalid-to-valid flags", chg_flag_o, 6'h3f);
    chk("R9 irq with flags", {5'b0, irq_o}, 6'h01);

    chg_clr = 6'h3f; step(1); chg_clr = '0;
    chk("R8 clear all flags", chg_flag_o, 6'h00);
    chk("R9 irq low when no flag", {5'b0, irq_o}, 6'h00);

    alm_noact[1] = 1'b1; step(1);
    chk("R1 no-activity drops input 1", valid_o, 6'h3d);
    chk("R7 valid-to-invalid flag", chg_flag_o, 6'h02);
    alm_freq[4] = 1'b1; step(1);
    chk("R1 freq alarm drops input 4", valid_o, 6'h2d);
    step(2);
    chk("R7 flags held", chg_flag_o, 6'h12);
    los_disq[5] = 1'b1; step(1);
    chk("R2 los drops input 5", valid_o, 6'h0d);
    alm_noact = '0; alm_freq = '0; los_disq = '0; chg_clr = 6'h3f; step(1);
    chk("R8 new change beats clear", chg_flag_o, 6'h32);
    chg_clr = '0;
    chk("R6 recovered", valid_o, 6'h3f);

    chg_clr = 6'h3f; step(1); chg_clr = '0;
    alm_phase[2] = 1'b1; step(1);
    chk("R3 phase alarm primary", valid_o, 6'h3b);
    rule_secondary = 1'b1; step(1);
    chk("R3 phase alarm ignored secondary", valid_o, 6'h3f);
    rule_secondary = 1'b0; alm_phase = '0; step(1);
    chg_clr = 6'h3f; step(1); chg_clr = '0;

    // Fast switch on input 3
    sel_idx = 3'd3; fast_sw_en = 1'b1; sel_edge = 1'b1; step(1); sel_edge = 1'b0;
    period_tick = 1'b1; step(2); period_tick = 1'b0;
    chk("R4 one miss still valid", valid_o, 6'h3f);
    step(1);
    chk("R4 two misses drop selected only", valid_o, 6'h37);
    fast_sw_en = 1'b0; step(1);
    chk("R4 criterion off keeps valid", valid_o, 6'h3f);
    fast_sw_en = 1'b1; rule_secondary = 1'b1; step(1);
    chk("R4 secondary ignores misses", valid_o, 6'h3f);
    rule_secondary = 1'b0; step(1);
    chk("R4 saturated count drops", valid_o, 6'h37);
    sel_edge = 1'b1; period_tick = 1'b1; step(1);
    sel_edge = 1'b0; period_tick = 1'b0; step(1);
    chk("R5 edge beats tick and restores", valid_o, 6'h3f);
    period_tick = 1'b1; step(5); period_tick = 1'b0;
    sel_idx = 3'd0; step(1);
    chk("R4 move selection to input 0", valid_o, 6'h3e);
    sel_edge = 1'b1; step(2); sel_edge = 1'b0;
    chk("R5 saturated count cleared by one edge", valid_o, 6'h3f);

    // Mixed pattern stress, checked by the model every cycle
    for (int k = 0; k < 400; k++) begin
      alm_noact = 6'($urandom) & 6'($urandom);
      alm_freq  = 6'($urandom) & 6'($urandom) & 6'($urandom);
      alm_phase = 6'($urandom) & 6'($urandom);
      los_disq  = 6'($urandom) & 6'($urandom) & 6'($urandom);
      chg_clr   = 6'($urandom);
      sel_idx   = 3'($urandom_range(0, 5));
      sel_edge  = ($urandom_range(0, 3) == 0);
      period_tick = ($urandom_range(0, 1) == 0);
      rule_secondary = ($urandom_range(0, 3) == 0);
      fast_sw_en = ($urandom_range(0, 3) != 0);
      step(1);
    end
    idle_inputs();
    step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule